// File: doc/BRIEF.md
# Spike-Triggered Synaptic Row Fetch Queue

This block sits between an address-event receiver and a memory copy engine in a spiking-network processing node. Every incoming event names the neuron that fired. The block looks that address up in a small associative table that software fills in. A hit gives a row number, which selects one block of synaptic weights in external memory. The block then reserves the next free slot of a circular set of local synaptic buffers and asks the copy engine to move the row into that slot. An optional 32-bit payload travels with the request.

Only one copy is in flight at a time. Hits that arrive while a copy is running wait in a small ordered queue. Events are never back-pressured: an event that finds every buffer reserved, or whose address is not in the table, is dropped and counted.

When a copy completes, the block acknowledges the completion so that the engine is free again. It then checks whether the consumer still has filled buffers to work through. If it has none, the block issues a single start pulse. If it has some, the consumer is already running and will reach the new buffer by itself. The consumer retires buffers strictly in order.

Top module: `spike_row_fetch`

## Requirements
- R1: After reset, `dma_req_valid`, `dma_done_ack`, `svc_start`, `buf_avail` and `overflow` are 0, both counters are 0, and `buf_slot` is 0.
- R2: A table entry written with `tbl_en`=1 matches an event whose address equals its key. An entry written with `tbl_en`=0 never matches. When several entries match, the entry with the lowest index supplies the row.
- R3: An event that hits while a buffer is free is presented as a copy request in the cycle after it arrives. The request carries the matched row, a slot number that counts 0,1,..,BUF_N-1,0,.. in arrival order from reset, and the payload flag. The payload field is the event's payload when the flag is 1 and 0 when the flag is 0.
- R4: An event whose address matches no enabled entry increments `miss_count` by one and produces no copy request.
- R5: A hitting event that arrives while all BUF_N slots are reserved (reserved but not yet retired) is dropped. It sets `overflow`, which stays set until reset, and increments `drop_count`. Both counters saturate at their all-ones value.
- R6: At most one copy is outstanding. After a request is accepted (`dma_req_valid` and `dma_req_ack` both 1), `dma_req_valid` stays 0 until the completion. A presented request holds its row and slot until it is accepted. Queued requests leave in arrival order.
- R7: A `dma_done` pulse while a copy is outstanding gives a one-cycle `dma_done_ack` in the following cycle. A `dma_done` with no copy outstanding gives no acknowledgement and fills no buffer.
- R8: `svc_start` pulses together with `dma_done_ack` exactly when, after any retirement in the completion cycle, no filled unretired buffer remains. Otherwise no start is issued.
- R9: `buf_avail` is 1 while filled, unretired buffers exist, and `buf_slot` names the oldest of them. `buf_retire` retires it. `buf_retire` with `buf_avail`=0 is ignored. A retired slot can be reserved again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | An event is present this cycle |
| pkt_addr | input | ADDR_W | Source neuron address of the event |
| pkt_has_pl | input | 1 | Event carries a payload |
| pkt_payload | input | 32 | Event payload |
| tbl_we | input | 1 | Write one lookup table entry |
| tbl_idx | input | log2(CAM_N) | Entry index to write |
| tbl_key | input | ADDR_W | Address key of the entry |
| tbl_row | input | ROW_W | Row number returned on a match |
| tbl_en | input | 1 | Entry enabled |
| dma_req_valid | output | 1 | Copy request presented |
| dma_req_ack | input | 1 | Copy engine accepts the request |
| dma_req_row | output | ROW_W | Row to fetch |
| dma_req_slot | output | log2(BUF_N) | Destination buffer slot |
| dma_req_has_pl | output | 1 | Payload flag of the originating event |
| dma_req_payload | output | 32 | Payload of the originating event, 0 if none |
| dma_done | input | 1 | Copy engine completion pulse |
| dma_done_ack | output | 1 | Completion acknowledgement pulse |
| svc_start | output | 1 | Start pulse for an idle consumer |
| buf_avail | output | 1 | A filled buffer awaits the consumer |
| buf_slot | output | log2(BUF_N) | Oldest filled buffer slot |
| buf_retire | input | 1 | Consumer finished the oldest buffer |
| overflow | output | 1 | Sticky: an event was dropped for lack of a slot |
| miss_count | output | CNT_W | Events that missed the table, saturating |
| drop_count | output | CNT_W | Events dropped for lack of a slot, saturating |

## Verification
The three ring pointers are invisible at the ports, so errors in them show up one or two cycles later through other outputs. A reservation pointer that drifts shows in `dma_req_slot` on the very next request. A fill pointer that drifts shows as a wrong `buf_avail`, or as a start pulse missing or doubled, in the cycle after a completion. A wrong in-flight flag lets a second request appear in the cycle after a handshake. Miscounted occupancy only comes to light at the boundary: either a drop appears early, or a slot number is reused while it is still reserved, on the event that crosses BUF_N. The bench drives each of these edges: a completion in the same cycle as a retirement, a retirement on an empty ring, and a long run of dropped events.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int PL_W = 32;

  typedef struct packed {
    logic            has;
    logic [PL_W-1:0] data;
  } pl_t;

  // payload is forced to zero when the event carries none
  function automatic logic [PL_W-1:0] pl_gate(input logic has, input logic [PL_W-1:0] d);
    return has ? d : '0;
  endfunction
endpackage

// File: rtl/srf_cam.sv
module srf_cam #(
  parameter int KEY_W   = 16,
  parameter int ROW_W   = 8,
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [KEY_W-1:0]           wr_key,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic                       wr_vld,
  input  logic [KEY_W-1:0]           lk_key,
  output logic                       lk_hit,
  output logic [ROW_W-1:0]           lk_row
);
  logic [ENTRIES-1:0] vld;
  logic [KEY_W-1:0]   key [ENTRIES];
  logic [ROW_W-1:0]   row [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        key[i] <= '0;
        row[i] <= '0;
      end
    end else if (wr_en) begin
      vld[wr_idx] <= wr_vld;
      key[wr_idx] <= wr_key;
      row[wr_idx] <= wr_row;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = vld[g] && (key[g] == lk_key);
  end

  // lowest matching index takes priority
  always_comb begin
    lk_hit = |hit_vec;
    lk_row = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) lk_row = row[i];
  end
endmodule

// File: rtl/srf_fifo.sv
module srf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp[AW-1:0]] <= din;

  assign empty = (wp == rp);
  assign dout  = mem[rp[AW-1:0]];
endmodule

// File: rtl/srf_ring.sv
module srf_ring #(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic                     fill_en,
  input  logic                     retire_req,
  output logic [$clog2(DEPTH)-1:0] alloc_slot,
  output logic [$clog2(DEPTH)-1:0] head_slot,
  output logic                     full,
  output logic                     avail,
  output logic                     retire_ok,
  output logic                     idle_next
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0] al, tl, hd, hd_next;

  function automatic logic [AW:0] span(input logic [AW:0] a, input logic [AW:0] b);
    return a - b;
  endfunction

  assign full       = (span(al, hd) == (AW+1)'(DEPTH));
  assign avail      = (tl != hd);
  assign retire_ok  = retire_req && avail;
  assign hd_next    = hd + (AW+1)'(retire_ok);
  assign idle_next  = (tl == hd_next);
  assign alloc_slot = al[AW-1:0];
  assign head_slot  = hd[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al <= '0;
      tl <= '0;
      hd <= '0;
    end else begin
      if (alloc_en) al <= al + 1'b1;
      if (fill_en)  tl <= tl + 1'b1;
      hd <= hd_next;
    end
  end
endmodule

// File: rtl/spike_row_fetch.sv
module spike_row_fetch
  import srf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8,
  parameter int CAM_N  = 8,
  parameter int BUF_N  = 4,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pkt_valid,
  input  logic [ADDR_W-1:0]        pkt_addr,
  input  logic                     pkt_has_pl,
  input  logic [PL_W-1:0]          pkt_payload,
  input  logic                     tbl_we,
  input  logic [$clog2(CAM_N)-1:0] tbl_idx,
  input  logic [ADDR_W-1:0]        tbl_key,
  input  logic [ROW_W-1:0]         tbl_row,
  input  logic                     tbl_en,
  output logic                     dma_req_valid,
  input  logic                     dma_req_ack,
  output logic [ROW_W-1:0]         dma_req_row,
  output logic [$clog2(BUF_N)-1:0] dma_req_slot,
  output logic                     dma_req_has_pl,
  output logic [PL_W-1:0]          dma_req_payload,
  input  logic                     dma_done,
  output logic                     dma_done_ack,
  output logic                     svc_start,
  output logic                     buf_avail,
  output logic [$clog2(BUF_N)-1:0] buf_slot,
  input  logic                     buf_retire,
  output logic                     overflow,
  output logic [CNT_W-1:0]         miss_count,
  output logic [CNT_W-1:0]         drop_count
);
  localparam int BW    = $clog2(BUF_N);
  localparam int REQ_W = ROW_W + BW + $bits(pl_t);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  logic             lk_hit;
  logic [ROW_W-1:0] lk_row;
  logic             full, idle_next, retire_ok;
  logic [BW-1:0]    alloc_slot;
  logic             q_empty;
  logic [REQ_W-1:0] q_din, q_dout;
  logic             busy;
  pl_t              pl_in, pl_out;

  // named internal events
  logic ev_hit, ev_miss, ev_drop, ev_issue, ev_done, ev_retire;

  srf_cam #(.KEY_W(ADDR_W), .ROW_W(ROW_W), .ENTRIES(CAM_N)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_key(tbl_key), .wr_row(tbl_row), .wr_vld(tbl_en),
    .lk_key(pkt_addr), .lk_hit(lk_hit), .lk_row(lk_row)
  );

  assign ev_hit  = pkt_valid && lk_hit && !full;
  assign ev_drop = pkt_valid && lk_hit && full;
  assign ev_miss = pkt_valid && !lk_hit;

  assign pl_in = '{has: pkt_has_pl, data: pl_gate(pkt_has_pl, pkt_payload)};
  assign q_din = {lk_row, alloc_slot, pl_in};

  // queue depth equals ring depth: every entry owns a reserved slot, so it cannot overflow
  srf_fifo #(.W(REQ_W), .DEPTH(BUF_N)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(ev_hit), .din(q_din), .pop(ev_issue), .dout(q_dout), .empty(q_empty)
  );

  assign {dma_req_row, dma_req_slot, pl_out} = q_dout;
  assign dma_req_has_pl  = pl_out.has;
  assign dma_req_payload = pl_out.data;
  assign dma_req_valid   = !q_empty && !busy;
  assign ev_issue        = dma_req_valid && dma_req_ack;
  assign ev_done         = dma_done && busy;

  srf_ring #(.DEPTH(BUF_N)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ev_hit), .fill_en(ev_done), .retire_req(buf_retire),
    .alloc_slot(alloc_slot), .head_slot(buf_slot),
    .full(full), .avail(buf_avail), .retire_ok(retire_ok), .idle_next(idle_next)
  );

  assign ev_retire = retire_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      dma_done_ack <= 1'b0;
      svc_start    <= 1'b0;
      overflow     <= 1'b0;
      miss_count   <= '0;
      drop_count   <= '0;
    end else begin
      if (ev_issue)     busy <= 1'b1;
      else if (ev_done) busy <= 1'b0;
      dma_done_ack <= ev_done;
      svc_start    <= ev_done && idle_next;
      if (ev_drop) begin
        overflow   <= 1'b1;
        drop_count <= sat_inc(drop_count);
      end
      if (ev_miss) miss_count <= sat_inc(miss_count);
    end
  end
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
  parameter int ROW_W = 8,
  parameter int BW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_req_valid,
  input logic             dma_req_ack,
  input logic [ROW_W-1:0] dma_req_row,
  input logic [BW-1:0]    dma_req_slot,
  input logic             ev_issue,
  input logic             ev_done,
  input logic             dma_done_ack,
  input logic             svc_start,
  input logic             overflow,
  input logic             buf_avail,
  input logic             buf_retire,
  input logic [BW-1:0]    buf_slot
);
  p_ack_follows_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> dma_done_ack);

  p_ack_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_ack |-> $past(ev_done));

  p_start_with_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_start |-> dma_done_ack);

  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> !dma_req_valid);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_valid && !dma_req_ack |=> dma_req_valid && $stable(dma_req_row) && $stable(dma_req_slot));

  p_overflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_retire_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_retire && !buf_avail |=> $stable(buf_slot));
endmodule

bind spike_row_fetch srf_checker #(.ROW_W(ROW_W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dma_req_valid(dma_req_valid), .dma_req_ack(dma_req_ack),
  .dma_req_row(dma_req_row), .dma_req_slot(dma_req_slot),
  .ev_issue(ev_issue), .ev_done(ev_done),
  .dma_done_ack(dma_done_ack), .svc_start(svc_start), .overflow(overflow),
  .buf_avail(buf_avail), .buf_retire(buf_retire), .buf_slot(buf_slot)
);

// File: tb/sim_spike_row_fetch.sv
module sim_spike_row_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [15:0] pkt_addr = '0;
  logic        pkt_has_pl = 1'b0;
  logic [31:0] pkt_payload = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [15:0] tbl_key = '0;
  logic [7:0]  tbl_row = '0;
  logic        tbl_en = 1'b0;
  logic        dma_req_valid;
  logic        dma_req_ack = 1'b0;
  logic [7:0]  dma_req_row;
  logic [1:0]  dma_req_slot;
  logic        dma_req_has_pl;
  logic [31:0] dma_req_payload;
  logic        dma_done = 1'b0;
  logic        dma_done_ack;
  logic        svc_start;
  logic        buf_avail;
  logic [1:0]  buf_slot;
  logic        buf_retire = 1'b0;
  logic        overflow;
  logic [7:0]  miss_count;
  logic [7:0]  drop_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spike_row_fetch u0 (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_has_pl(pkt_has_pl), .pkt_payload(pkt_payload),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_key(tbl_key), .tbl_row(tbl_row), .tbl_en(tbl_en),
    .dma_req_valid(dma_req_valid), .dma_req_ack(dma_req_ack), .dma_req_row(dma_req_row),
    .dma_req_slot(dma_req_slot), .dma_req_has_pl(dma_req_has_pl), .dma_req_payload(dma_req_payload),
    .dma_done(dma_done), .dma_done_ack(dma_done_ack), .svc_start(svc_start),
    .buf_avail(buf_avail), .buf_slot(buf_slot), .buf_retire(buf_retire),
    .overflow(overflow), .miss_count(miss_count), .drop_count(drop_count)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic tbl_write(input logic [2:0] idx, input logic [15:0] key, input logic [7:0] row, input logic en);
    tbl_we = 1'b1; tbl_idx = idx; tbl_key = key; tbl_row = row; tbl_en = en;
    step();
    tbl_we = 1'b0;
  endtask

  task automatic send_pkt(input logic [15:0] addr, input logic has, input logic [31:0] pl);
    pkt_valid = 1'b1; pkt_addr = addr; pkt_has_pl = has; pkt_payload = pl;
    step();
    pkt_valid = 1'b0;
  endtask

  task automatic accept();
    dma_req_ack = 1'b1;
    step();
    dma_req_ack = 1'b0;
  endtask

  task automatic complete();
    dma_done = 1'b1;
    step();
    dma_done = 1'b0;
  endtask

  task automatic retire();
    buf_retire = 1'b1;
    step();
    buf_retire = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "dma_req_valid", dma_req_valid, 0);
    chk("R1", "dma_done_ack", dma_done_ack, 0);
    chk("R1", "svc_start", svc_start, 0);
    chk("R1", "buf_avail", buf_avail, 0);
    chk("R1", "buf_slot", buf_slot, 0);
    chk("R1", "overflow", overflow, 0);
    chk("R1", "miss_count", miss_count, 0);
    chk("R1", "drop_count", drop_count, 0);
  endtask

  task automatic t_miss();
    send_pkt(16'h0999, 1'b0, 32'h0);
    chk("R4", "miss_count unknown addr", miss_count, 1);
    chk("R4", "no request on miss", dma_req_valid, 0);
    send_pkt(16'h0300, 1'b0, 32'h0);
    chk("R2", "disabled entry misses", miss_count, 2);
    chk("R2", "no request from disabled entry", dma_req_valid, 0);
  endtask

  task automatic t_hit_flow();
    send_pkt(16'h0100, 1'b1, 32'hDEADBEEF);
    chk("R3", "request valid", dma_req_valid, 1);
    chk("R3", "request row", dma_req_row, 5);
    chk("R3", "request slot", dma_req_slot, 0);
    chk("R3", "payload flag", dma_req_has_pl, 1);
    chk("R3", "payload", dma_req_payload, 32'hDEADBEEF);
    step();
    chk("R6", "request held without ack", dma_req_valid, 1);
    chk("R6", "row held without ack", dma_req_row, 5);
    accept();
    chk("R6", "no request while outstanding", dma_req_valid, 0);
    send_pkt(16'h0200, 1'b0, 32'h1234);
    chk("R6", "queued hit waits", dma_req_valid, 0);
    complete();
    chk("R7", "done ack", dma_done_ack, 1);
    chk("R8", "start on idle consumer", svc_start, 1);
    chk("R9", "buffer available", buf_avail, 1);
    chk("R9", "oldest slot", buf_slot, 0);
    chk("R6", "queued request released", dma_req_valid, 1);
    chk("R2", "lowest index wins", dma_req_row, 7);
    chk("R3", "second slot", dma_req_slot, 1);
    chk("R3", "no payload flag", dma_req_has_pl, 0);
    chk("R3", "payload zeroed", dma_req_payload, 0);
    accept();
    chk("R7", "ack is one cycle", dma_done_ack, 0);
    complete();
    chk("R7", "second done ack", dma_done_ack, 1);
    chk("R8", "no start while consumer busy", svc_start, 0);
    retire();
    chk("R9", "next slot after retire", buf_slot, 1);
    chk("R9", "still available", buf_avail, 1);
    retire();
    chk("R9", "empty after retires", buf_avail, 0);
    retire();
    chk("R9", "retire on empty ignored", buf_slot, 2);
    chk("R9", "still empty", buf_avail, 0);
    complete();
    chk("R7", "stray done not acked", dma_done_ack, 0);
    chk("R7", "stray done fills nothing", buf_avail, 0);
    chk("R8", "stray done no start", svc_start, 0);
  endtask

  task automatic t_race();
    send_pkt(16'h0100, 1'b0, 32'h0);
    chk("R3", "slot 2 reserved", dma_req_slot, 2);
    accept();
    complete();
    chk("R8", "start for slot 2", svc_start, 1);
    send_pkt(16'h0100, 1'b0, 32'h0);
    accept();
    dma_done = 1'b1; buf_retire = 1'b1;
    step();
    dma_done = 1'b0; buf_retire = 1'b0;
    chk("R8", "start when retire empties ring", svc_start, 1);
    chk("R9", "slot 3 now oldest", buf_slot, 3);
    retire();
    chk("R9", "drained", buf_avail, 0);
  endtask

  task automatic t_full();
    for (int k = 0; k < 4; k++) send_pkt(16'h0200, 1'b0, 32'h0);
    chk("R5", "no drop up to depth", drop_count, 0);
    chk("R5", "no overflow up to depth", overflow, 0);
    send_pkt(16'h0200, 1'b0, 32'h0);
    chk("R5", "drop when full", drop_count, 1);
    chk("R5", "overflow set", overflow, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R6", "queued order slot", dma_req_slot, k);
      accept();
      complete();
      chk("R8", "start only for first", svc_start, (k == 0));
    end
    retire();
    send_pkt(16'h0100, 1'b0, 32'h0);
    chk("R9", "freed slot accepted", drop_count, 1);
    chk("R9", "freed slot reused", dma_req_slot, 0);
    pkt_valid = 1'b1; pkt_addr = 16'h0100; pkt_has_pl = 1'b0;
    repeat (260) step();
    pkt_valid = 1'b0;
    chk("R5", "drop counter saturates", drop_count, 8'hFF);
    chk("R5", "overflow sticky", overflow, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL all-requirements watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    @(negedge clk);
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    tbl_write(3'd0, 16'h0100, 8'd5, 1'b1);
    tbl_write(3'd1, 16'h0200, 8'd7, 1'b1);
    tbl_write(3'd2, 16'h0300, 8'd9, 1'b0);
    tbl_write(3'd3, 16'h0200, 8'd11, 1'b1);
    t_miss();
    t_hit_flow();
    t_race();
    t_full();
    report();
  end
endmodule